// File: doc/BRIEF.md
# Check-Gated In-Order Retirement Buffer

This block is a circular reorder buffer. Instructions enter at the tail in program order, one per cycle, and leave from the head in the same order. Each slot carries a done-executing bit and two operand-check flags, one per possible source operand. A flag is raised by an event that names the slot and the operand. The event means that the operand read has finished its integrity check, or that it was never protected. Operands that an instruction does not have get their flags raised when it is dispatched.

The head retires when it is done executing and both of its flags are raised. When the buffer is full, the flags are bypassed so the pipeline does not stall: a done head retires whatever its flags hold. A recovery request flushes every slot from a given index up to the tail. That index is the oldest reader of a corrupted register. Flag and done events aimed at slots that are not occupied have no effect.

Top module: `chk_rob`

## Requirements
- R1: After reset the buffer is empty, not full, offers no retirement, accepts dispatch and allocates slot 0 first.
- R2: Slots are allocated in increasing index order, one per accepted dispatch, wrapping from DEPTH-1 to 0; `disp_idx` shows the slot the next dispatch takes.
- R3: `disp_nops` gives the operand count: 0 raises both flags at dispatch, 1 raises the operand-1 flag only, 2 (or 3) raises neither. A check event with `chk_op`=0 raises the operand-0 flag and `chk_op`=1 raises the operand-1 flag.
- R4: When the buffer is not full, the head retires only if it is done and both flags are raised; younger ready slots wait behind it.
- R5: When the buffer is full, the head retires as soon as it is done, regardless of its flags.
- R6: Dispatch is refused when the buffer is full unless the head retires in the same cycle, in which case the freed place is refilled in that cycle.
- R7: A flush with index F makes F the next allocated slot and discards F and every younger slot. In the flush cycle there is no dispatch and no retirement. A flush at the head slot leaves the buffer empty.
- R8: Check and done events aimed at a free or flushed slot are ignored; a slot that is later reallocated starts from its dispatch-time flags and not done.
- R9: `retire_idx` names the retiring slot, and slots retire in exactly their allocation order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch request |
| disp_nops | input | 2 | Number of source operands of the dispatched instruction |
| disp_ready | output | 1 | Dispatch is accepted this cycle |
| disp_idx | output | $clog2(DEPTH) | Slot the next dispatch occupies |
| chk_valid | input | 1 | Operand-check completion event |
| chk_idx | input | $clog2(DEPTH) | Slot of the check event |
| chk_op | input | 1 | Operand of the check event (0 or 1) |
| done_valid | input | 1 | Execution-done event |
| done_idx | input | $clog2(DEPTH) | Slot of the done event |
| flush_valid | input | 1 | Recovery flush request |
| flush_idx | input | $clog2(DEPTH) | First slot to discard |
| retire_valid | output | 1 | Head retires this cycle |
| retire_idx | output | $clog2(DEPTH) | Slot retiring this cycle |
| full | output | 1 | All DEPTH slots occupied |
| empty | output | 1 | No slot occupied |

## Verification
The retirement gate is driven with one-, two- and zero-operand instructions whose flags arrive in different orders. This shows whether a missing operand-0 or operand-1 flag holds the head, and whether a ready younger slot can pass it. The buffer is then filled to capacity with unchecked instructions. That separates the full-buffer bypass and the retire-and-refill cycle from the normal gate. Flushes in the middle of the buffer and at the head, followed by events aimed at the discarded slots and by reallocation of those slots, show that stale events leave no trace.

// File: rtl/chk_rob.sv
module chk_rob #(
  parameter int DEPTH = 16,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          disp_valid,
  input  logic [1:0]    disp_nops,
  output logic          disp_ready,
  output logic [IW-1:0] disp_idx,
  input  logic          chk_valid,
  input  logic [IW-1:0] chk_idx,
  input  logic          chk_op,
  input  logic          done_valid,
  input  logic [IW-1:0] done_idx,
  input  logic          flush_valid,
  input  logic [IW-1:0] flush_idx,
  output logic          retire_valid,
  output logic [IW-1:0] retire_idx,
  output logic          full,
  output logic          empty
);

  logic [IW:0]       head, tail, cnt;
  logic [DEPTH-1:0]  vld, dn, f0, f1;
  logic [IW-1:0]     hs, ts, fdist;
  logic              disp_go;

  assign hs    = head[IW-1:0];
  assign ts    = tail[IW-1:0];
  assign cnt   = tail - head;
  assign full  = cnt == (IW+1)'(DEPTH);
  assign empty = cnt == '0;
  assign fdist = flush_idx - hs;

  assign retire_valid = !flush_valid && vld[hs] && dn[hs] && ((f0[hs] && f1[hs]) || full);
  assign retire_idx   = hs;
  assign disp_ready   = !flush_valid && (!full || retire_valid);
  assign disp_idx     = ts;
  assign disp_go      = disp_valid && disp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head <= '0;
      tail <= '0;
      vld  <= '0;
      dn   <= '0;
      f0   <= '0;
      f1   <= '0;
    end else begin
      if (chk_valid && vld[chk_idx]) begin
        if (chk_op) f1[chk_idx] <= 1'b1;
        else        f0[chk_idx] <= 1'b1;
      end
      if (done_valid && vld[done_idx]) dn[done_idx] <= 1'b1;
      if (flush_valid) begin
        tail <= head + {1'b0, fdist};
        for (int i = 0; i < DEPTH; i++)
          if (IW'(IW'(i) - hs) >= fdist) vld[i] <= 1'b0;
      end else begin
        if (retire_valid) begin
          vld[hs] <= 1'b0;
          head    <= head + 1'b1;
        end
        if (disp_go) begin
          vld[ts] <= 1'b1;
          dn[ts]  <= 1'b0;
          f0[ts]  <= disp_nops == 2'd0;
          f1[ts]  <= disp_nops < 2'd2;
          tail    <= tail + 1'b1;
        end
      end
    end
  end

  p_occupancy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(vld) == int'(cnt));

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) <= DEPTH);

  p_refuse_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    full && disp_valid && !retire_valid && !flush_valid |=> tail == $past(tail));

  p_flush_tail_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |=> ts == $past(flush_idx));

  p_retire_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    retire_valid |=> head == (IW+1)'($past(head) + 1));

  p_hold_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
    retire_valid && !full |-> f0[hs] && f1[hs]);

endmodule

// File: tb/chk_rob_tb.sv
module chk_rob_tb;
  localparam int DEPTH = 16;
  localparam int IW = $clog2(DEPTH);

  logic clk = 0, rst_n = 0;
  logic disp_valid = 0, chk_valid = 0, chk_op = 0, done_valid = 0, flush_valid = 0;
  logic [1:0] disp_nops = 0;
  logic [IW-1:0] chk_idx = 0, done_idx = 0, flush_idx = 0;
  logic disp_ready, retire_valid, full, empty;
  logic [IW-1:0] disp_idx, retire_idx;

  int checks = 0, failures = 0, exp_tail = 0, cycles = 0;
  int exp_q[$];
  bit finished = 0;

  always #5 clk = ~clk;

  chk_rob #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .disp_valid(disp_valid), .disp_nops(disp_nops), .disp_ready(disp_ready), .disp_idx(disp_idx),
    .chk_valid(chk_valid), .chk_idx(chk_idx), .chk_op(chk_op),
    .done_valid(done_valid), .done_idx(done_idx),
    .flush_valid(flush_valid), .flush_idx(flush_idx),
    .retire_valid(retire_valid), .retire_idx(retire_idx),
    .full(full), .empty(empty));

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // scoreboard monitor: R9 in-order retirement
  always @(negedge clk) begin
    if (rst_n && retire_valid) begin
      if (exp_q.size() == 0) check("R9 unexpected retire", int'(retire_idx), -1);
      else check("R9 retire order", int'(retire_idx), exp_q.pop_front());
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      check("watchdog", 1, 0);
      summary();
    end
  end

  task automatic step();
    @(posedge clk); #1;
    disp_valid = 0; chk_valid = 0; done_valid = 0; flush_valid = 0;
  endtask

  task automatic dispatch(int nops, int ready_exp, string req);
    disp_valid = 1; disp_nops = 2'(nops);
    @(negedge clk);
    check({req, " disp_ready"}, int'(disp_ready), ready_exp);
    check("R2 disp_idx", int'(disp_idx), exp_tail);
    if (disp_ready) begin
      exp_q.push_back(exp_tail);
      exp_tail = (exp_tail + 1) % DEPTH;
    end
    step();
  endtask

  task automatic ev_chk(int idx, int op);
    chk_valid = 1; chk_idx = IW'(idx); chk_op = op[0];
    step();
  endtask

  task automatic ev_done(int idx);
    done_valid = 1; done_idx = IW'(idx);
    step();
  endtask

  task automatic do_flush(int f);
    int pos;
    flush_valid = 1; flush_idx = IW'(f);
    @(negedge clk);
    check("R7 no retire in flush", int'(retire_valid), 0);
    check("R7 no dispatch in flush", int'(disp_ready), 0);
    pos = -1;
    foreach (exp_q[k]) if (pos < 0 && exp_q[k] == f) pos = k;
    if (pos >= 0) while (exp_q.size() > pos) void'(exp_q.pop_back());
    exp_tail = f;
    step();
  endtask

  task automatic expect_retire(string req, int v, int idx);
    @(negedge clk);
    check({req, " retire_valid"}, int'(retire_valid), v);
    if (v) check({req, " retire_idx"}, int'(retire_idx), idx);
  endtask

  initial begin
    step(); step();
    rst_n = 1;
    @(negedge clk);
    check("R1 empty", int'(empty), 1);
    check("R1 full", int'(full), 0);
    check("R1 retire_valid", int'(retire_valid), 0);
    check("R1 disp_ready", int'(disp_ready), 1);
    check("R1 disp_idx", int'(disp_idx), 0);
    step();

    // R3/R4: two-, one-, zero-operand instructions
    dispatch(2, 1, "R2");
    dispatch(1, 1, "R2");
    dispatch(0, 1, "R2");
    ev_done(0); ev_done(1); ev_done(2);
    expect_retire("R4 head waits for flags", 0, 0);
    ev_chk(0, 0);
    expect_retire("R4 head waits for operand-1 flag", 0, 0);
    step();
    ev_chk(0, 1);
    expect_retire("R4 head retires with both flags", 1, 0);
    step();
    expect_retire("R3 one-operand waits for op0", 0, 0);
    step();
    ev_chk(1, 0);
    expect_retire("R3 one-operand retires", 1, 1);
    step();
    expect_retire("R3 zero-operand retires", 1, 2);
    step();
    @(negedge clk);
    check("R9 empty after drain", int'(empty), 1);
    step();

    // R5/R6: fill with unchecked instructions
    for (int k = 0; k < DEPTH; k++) dispatch(2, 1, "R6");
    @(negedge clk);
    check("R6 full", int'(full), 1);
    step();
    dispatch(2, 0, "R6 refused when full");
    @(negedge clk);
    check("R6 tail unchanged", int'(disp_idx), 3);
    check("R6 still full", int'(full), 1);
    step();
    ev_done(3);
    dispatch(0, 1, "R5/R6 retire and refill");
    @(negedge clk);
    check("R6 full after refill", int'(full), 1);
    step();
    ev_done(4);
    expect_retire("R5 full bypasses flags", 1, 4);
    step();
    ev_done(5);
    expect_retire("R4 not full, flags missing", 0, 0);
    check("R5 no longer full", int'(full), 0);
    step();

    // R7: flush in the middle
    do_flush(8);
    @(negedge clk);
    check("R7 disp_idx after flush", int'(disp_idx), 8);
    check("R7 not empty", int'(empty), 0);
    check("R7 not full", int'(full), 0);
    step();

    // R8: events aimed at flushed slot 9
    ev_chk(9, 0); ev_chk(9, 1); ev_done(9);
    for (int s = 5; s < 8; s++) begin
      ev_chk(s, 0); ev_chk(s, 1);
      if (s != 5) ev_done(s);
    end
    step(); step();
    @(negedge clk);
    check("R7 drained after flush", int'(empty), 1);
    check("R9 scoreboard drained", exp_q.size(), 0);
    step();

    dispatch(2, 1, "R8");
    dispatch(2, 1, "R8");
    ev_done(8); ev_done(9);
    ev_chk(8, 0); ev_chk(8, 1);
    expect_retire("R8 slot 8 retires", 1, 8);
    step();
    expect_retire("R8 stale flags on slot 9 ignored", 0, 0);
    step();
    ev_chk(9, 0); ev_chk(9, 1);
    expect_retire("R8 slot 9 retires after own flags", 1, 9);
    step();

    // R7: flush at head
    dispatch(1, 1, "R7");
    dispatch(1, 1, "R7");
    dispatch(1, 1, "R7");
    do_flush(10);
    @(negedge clk);
    check("R7 flush at head empties", int'(empty), 1);
    check("R7 disp_idx at head", int'(disp_idx), 10);
    step();
    ev_done(10);
    expect_retire("R8 done on flushed head ignored", 0, 0);
    step();

    summary();
  end
endmodule